// File: doc/BRIEF.md
# Receive Cell Bus Poll-and-Select Master

This block sits on the ATM-layer side of a shared receive cell bus with several PHY devices. Every clock it puts one PHY address from a fixed poll list on the 5-bit address bus. On the following edge it records that PHY's cell-available answer in a ready bitmap. The all-ones address marks an empty slot: whatever answer comes back for it is thrown away.

When no transfer is running and at least one PHY has reported a cell, the master chooses one PHY round-robin. For one cycle it drives that PHY's address with the active-low enable deasserted. It then holds enable low to read 27 sixteen-bit words. While the words arrive, the address bus goes back to polling the list, so the bitmap stays current for the next choice.

The first word of a cell must carry start-of-cell. If it does not, an error flag pulses for one cycle and incoming words are discarded until start-of-cell appears. Enable stays low for one extra cycle for each discarded word. Accepted words leave on a valid/data port that has first and last markers and no backpressure.

Top module: `utopia_rx_poll_master`

## Requirements
- R1: Outside a select cycle, the address bus steps through the poll list in index order, one entry per clock, and wraps at the end. With the default list the order is 01h, 02h, 03h, 1Fh. After reset the first address is 01h.
- R2: A high cell-available answer for address 1Fh is ignored: that address is never selected and never starts a read.
- R3: A PHY whose most recent poll was sampled low is not selected. The answer for an address driven in a cycle is the cell-available level at the clock edge that ends that cycle.
- R4: A selection is one cycle with the target address on the bus and enable high, followed at once by enable low. Enable is never low except during a cell read.
- R5: A cell is 27 words. The word sampled with start-of-cell is output with first=1. The 27th accepted word is output with last=1. Data passes unchanged, and no word is output outside a cell.
- R6: Polling continues while a cell is being read, so every list address appears on the bus during the read.
- R7: Selection is round-robin by poll-list index, starting after the PHY served last, so that PHY has the lowest priority. It is chosen again only if no other PHY is ready.
- R8: If the first word after a selection lacks start-of-cell, the error output pulses high for exactly one cycle. Words are then dropped without output until start-of-cell is seen, and that word begins the cell.
- R9: During reset, enable is high (negated), valid and error are low, and the address bus shows the first list entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| utp_addr | output | 5 | PHY address for polling or selection |
| utp_enb_n | output | 1 | Active-low read enable |
| utp_clav | input | 1 | Cell-available answer from the polled PHY |
| utp_data | input | 16 | Receive data word |
| utp_soc | input | 1 | Start-of-cell marker for the current word |
| cell_valid | output | 1 | Output word valid |
| cell_data | output | 16 | Output word |
| cell_first | output | 1 | Word is the first of a cell |
| cell_last | output | 1 | Word is the last of a cell |
| soc_error | output | 1 | One-cycle pulse when start-of-cell is missing on the first word |

## Verification
The round-robin order can only be observed once several PHYs have cells queued at the moment a transfer ends. To get there, the bench PHY model loads two cells into every PHY at once and checks each selection that follows a finished cell against the next pending PHY in list order. A separate case makes one PHY prefix every cell with junk words, which drives the master into discarding words and extending enable. A third case makes the empty 1Fh slot answer high throughout, to show that the answer is ignored.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

    localparam int ADDR_W = 5;
    localparam int WORD_W = 16;
    localparam logic [ADDR_W-1:0] NULL_ADDR = 5'h1F;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL,
        ST_READ
    } ctl_state_e;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic              last;
        logic [WORD_W-1:0] data;
    } cell_word_t;

endpackage

// File: rtl/urx_poll_sched.sv
module urx_poll_sched
    import utopia_rx_pkg::*;
#(
    parameter int NUM_PHY = 4,
    parameter logic [NUM_PHY*ADDR_W-1:0] PHY_LIST = {5'h1F, 5'h03, 5'h02, 5'h01},
    localparam int IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [IDX_W-1:0]   tgt_idx,
    input  logic               clav,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [NUM_PHY-1:0] ready
);
    logic [ADDR_W-1:0] tbl [NUM_PHY];
    logic [IDX_W-1:0]  pidx;

    for (genvar g = 0; g < NUM_PHY; g++) begin : g_tbl
        assign tbl[g] = PHY_LIST[g*ADDR_W +: ADDR_W];
    end

    assign bus_addr = hold ? tbl[tgt_idx] : tbl[pidx];

    always_ff @(posedge clk) begin
        if (rst) begin
            pidx  <= '0;
            ready <= '0;
        end else begin
            if (!hold) begin
                if (tbl[pidx] != NULL_ADDR)
                    ready[pidx] <= clav;
                pidx <= (pidx == IDX_W'(NUM_PHY - 1)) ? '0 : pidx + IDX_W'(1);
            end
            if (clr_en)
                ready[clr_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/urx_rr_arbiter.sv
module urx_rr_arbiter #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx
);
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = last;
        for (int k = N; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                grant_valid = 1'b1;
                grant_idx   = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/urx_cell_receiver.sv
module urx_cell_receiver
    import utopia_rx_pkg::*;
#(
    parameter int CELL_WORDS = 27,
    localparam int CNT_W = $clog2(CELL_WORDS + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              en_low,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_soc,
    output cell_word_t        ow,
    output logic              soc_err,
    output logic              drop,
    output logic              done
);
    logic             rd_q;
    logic             hunting;
    logic             first_chk;
    logic [CNT_W-1:0] wcnt;

    assign drop = rd_q && hunting && !rx_soc;
    assign done = rd_q && !hunting && (wcnt == CNT_W'(CELL_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= 1'b0;
            hunting   <= 1'b0;
            first_chk <= 1'b0;
            wcnt      <= '0;
            ow        <= '0;
            soc_err   <= 1'b0;
        end else begin
            rd_q     <= en_low;
            ow.valid <= 1'b0;
            ow.first <= 1'b0;
            ow.last  <= 1'b0;
            soc_err  <= 1'b0;
            if (start) begin
                hunting   <= 1'b1;
                first_chk <= 1'b1;
                wcnt      <= '0;
            end else if (rd_q) begin
                if (hunting) begin
                    if (rx_soc) begin
                        ow.valid  <= 1'b1;
                        ow.first  <= 1'b1;
                        ow.data   <= rx_data;
                        hunting   <= 1'b0;
                        first_chk <= 1'b0;
                        wcnt      <= CNT_W'(1);
                    end else begin
                        if (first_chk)
                            soc_err <= 1'b1;
                        first_chk <= 1'b0;
                    end
                end else begin
                    ow.valid <= 1'b1;
                    ow.data  <= rx_data;
                    wcnt     <= wcnt + CNT_W'(1);
                    if (wcnt == CNT_W'(CELL_WORDS - 1))
                        ow.last <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/utopia_rx_poll_master.sv
module utopia_rx_poll_master
    import utopia_rx_pkg::*;
#(
    parameter int NUM_PHY = 4,
    parameter logic [NUM_PHY*ADDR_W-1:0] PHY_LIST = {5'h1F, 5'h03, 5'h02, 5'h01},
    parameter int CELL_WORDS = 27
)(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] utp_addr,
    output logic              utp_enb_n,
    input  logic              utp_clav,
    input  logic [WORD_W-1:0] utp_data,
    input  logic              utp_soc,
    output logic              cell_valid,
    output logic [WORD_W-1:0] cell_data,
    output logic              cell_first,
    output logic              cell_last,
    output logic              soc_error
);
    localparam int IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;
    localparam int REM_W = $clog2(CELL_WORDS + 1) + 1;

    ctl_state_e       st;
    logic [IDX_W-1:0] tgt;
    logic [IDX_W-1:0] last_srv;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_valid;
    logic [NUM_PHY-1:0] ready;
    logic [REM_W-1:0] remaining;
    logic             en_low;
    logic             word_drop;
    logic             cell_done;
    cell_word_t       ow;

    assign en_low    = (st == ST_READ) && (remaining != '0);
    assign utp_enb_n = ~en_low;

    urx_poll_sched #(.NUM_PHY(NUM_PHY), .PHY_LIST(PHY_LIST)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .hold     (st == ST_SEL),
        .tgt_idx  (tgt),
        .clav     (utp_clav),
        .clr_en   ((st == ST_IDLE) && grant_valid),
        .clr_idx  (grant_idx),
        .bus_addr (utp_addr),
        .ready    (ready)
    );

    urx_rr_arbiter #(.N(NUM_PHY)) u_arb (
        .req         (ready),
        .last        (last_srv),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    urx_cell_receiver #(.CELL_WORDS(CELL_WORDS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .start   (st == ST_SEL),
        .en_low  (en_low),
        .rx_data (utp_data),
        .rx_soc  (utp_soc),
        .ow      (ow),
        .soc_err (soc_error),
        .drop    (word_drop),
        .done    (cell_done)
    );

    assign cell_valid = ow.valid;
    assign cell_data  = ow.data;
    assign cell_first = ow.first;
    assign cell_last  = ow.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            tgt       <= '0;
            last_srv  <= IDX_W'(NUM_PHY - 1);
            remaining <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (grant_valid) begin
                        tgt <= grant_idx;
                        st  <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    remaining <= REM_W'(CELL_WORDS);
                    st        <= ST_READ;
                end
                ST_READ: begin
                    remaining <= remaining - REM_W'(en_low) + REM_W'(word_drop);
                    if (cell_done) begin
                        last_srv <= tgt;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/utopia_rx_master_chk.sv
module utopia_rx_master_chk
    import utopia_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctl_state_e        st,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              enb_n,
    input logic              soc_in,
    input logic              valid,
    input logic              first,
    input logic              last,
    input logic              err
);
    assert_poll_steps_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && st != ST_SEL && $past(st) != ST_SEL) |-> bus_addr != $past(bus_addr));

    assert_sel_not_null_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SEL) |-> (bus_addr != NULL_ADDR && enb_n));

    assert_enb_follows_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SEL) |=> !enb_n);

    assert_flags_need_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (first || last) |-> valid);

    assert_first_had_soc_R5: assert property (@(posedge clk) disable iff (rst)
        first |-> $past(soc_in));

    assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
endmodule

bind utopia_rx_poll_master utopia_rx_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .bus_addr (utp_addr),
    .enb_n    (utp_enb_n),
    .soc_in   (utp_soc),
    .valid    (cell_valid),
    .first    (cell_first),
    .last     (cell_last),
    .err      (soc_error)
);

// File: tb/tb_utopia_rx_poll_master.sv
`timescale 1ns/1ps
module tb_utopia_rx_poll_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  utp_addr;
    logic        utp_enb_n;
    logic        utp_clav = 1'b0;
    logic [15:0] utp_data = 16'h0;
    logic        utp_soc = 1'b0;
    logic        cell_valid;
    logic [15:0] cell_data;
    logic        cell_first;
    logic        cell_last;
    logic        soc_error;

    always #4 clk = ~clk;

    utopia_rx_poll_master dut (
        .clk(clk), .rst(rst), .utp_addr(utp_addr), .utp_enb_n(utp_enb_n),
        .utp_clav(utp_clav), .utp_data(utp_data), .utp_soc(utp_soc),
        .cell_valid(cell_valid), .cell_data(cell_data), .cell_first(cell_first),
        .cell_last(cell_last), .soc_error(soc_error)
    );

    typedef struct packed {
        logic [3:0] c1, c2, c3;
        logic [3:0] j1, j2, j3;
        logic [3:0] cells, errs;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0},
        '{4'd0, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2, 4'd0},
        '{4'd2, 4'd2, 4'd2, 4'd0, 4'd0, 4'd0, 4'd6, 4'd0},
        '{4'd0, 4'd1, 4'd0, 4'd0, 4'd3, 4'd0, 4'd1, 4'd1},
        '{4'd1, 4'd1, 4'd1, 4'd0, 4'd0, 4'd2, 4'd3, 4'd1},
        '{4'd0, 4'd0, 4'd3, 4'd1, 4'd0, 4'd1, 4'd3, 4'd3}
    };
    localparam logic [4:0] LIST [4] = '{5'h01, 5'h02, 5'h03, 5'h1F};

    int n_tests = 0;
    int n_fail = 0;
    int pend [4];
    int junk [4];
    int cells_done = 0;
    int errs_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // PHY model and output monitor
    initial begin
        bit         en_last = 1'b1;
        logic [4:0] addr_last = 5'h0;
        bit         reading = 1'b0;
        bit         exp_first = 1'b0;
        int         sel = 0;
        int         prev_sel = -1;
        int         jl = 0;
        int         w = 0;
        int         mon_w = 0;
        int         gap = 100;
        bit [3:0]   seen = '0;
        for (int i = 0; i < 4; i++) begin
            pend[i] = 0;
            junk[i] = 0;
        end
        forever begin
            @(negedge clk);
            if (rst) begin
                en_last = 1'b1;
                continue;
            end
            gap++;
            if (soc_error) errs_seen++;
            if (cell_valid) begin
                chk(cell_first == exp_first, "R5 first flag", cell_first, exp_first);
                chk(cell_last == (mon_w == 26), "R5 last flag", cell_last, mon_w == 26);
                chk(cell_data == {sel[4:0], 3'b000, 8'(mon_w)}, "R5 R8 word data",
                    cell_data, {sel[4:0], 3'b000, 8'(mon_w)});
                exp_first = 1'b0;
                mon_w++;
                if (cell_last) cells_done++;
            end
            if (!utp_enb_n && en_last && !reading) begin
                int a;
                a = int'(addr_last);
                chk(a != 31, "R2 null address selected", a, 0);
                chk(a >= 1 && a <= 3 && pend[a & 3] > 0, "R3 selected PHY had a cell", a, 0);
                if (prev_sel > 0 && gap <= 6 && a >= 1 && a <= 3) begin
                    int e;
                    e = prev_sel;
                    for (int k = 3; k >= 1; k--) begin
                        int c;
                        c = ((prev_sel - 1 + k) % 3) + 1;
                        if (pend[c] > 0) e = c;
                    end
                    chk(a == e, "R7 round-robin order", a, e);
                end
                if (a >= 1 && a <= 3) begin
                    pend[a]--;
                    jl = junk[a];
                end
                reading = 1'b1;
                w = 0;
                mon_w = 0;
                sel = a;
                prev_sel = a;
                seen = '0;
                exp_first = 1'b1;
            end
            if (!utp_enb_n) begin
                for (int i = 0; i < 4; i++)
                    if (utp_addr == LIST[i]) seen[i] = 1'b1;
            end
            if (!en_last && reading) begin
                if (jl > 0) begin
                    utp_data = 16'hBAD0;
                    utp_soc  = 1'b0;
                    jl--;
                end else begin
                    utp_data = {sel[4:0], 3'b000, 8'(w)};
                    utp_soc  = (w == 0);
                    w++;
                    if (w == 27) begin
                        reading = 1'b0;
                        gap = 0;
                        chk(seen == 4'hF, "R6 polling during read", seen, 4'hF);
                    end
                end
            end else begin
                utp_data = 16'h0;
                utp_soc  = 1'b0;
            end
            if (utp_addr == 5'h1F)
                utp_clav = 1'b1;
            else if (utp_addr >= 5'd1 && utp_addr <= 5'd3)
                utp_clav = pend[utp_addr[1:0]] > 0;
            else
                utp_clav = 1'b0;
            en_last = utp_enb_n;
            addr_last = utp_addr;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cells_done, 16);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(utp_enb_n == 1'b1, "R9 enable negated in reset", utp_enb_n, 1);
        chk(cell_valid == 1'b0, "R9 valid low in reset", cell_valid, 0);
        chk(soc_error == 1'b0, "R9 error low in reset", soc_error, 0);
        chk(utp_addr == 5'h01, "R9 first list address", utp_addr, 5'h01);
        rst = 1'b0;
        // directed: poll order with the null slot answering high
        for (int k = 0; k < 8; k++) begin
            chk(utp_addr == LIST[k % 4], "R1 poll order", utp_addr, LIST[k % 4]);
            chk(utp_enb_n == 1'b1, "R2 null answer ignored", utp_enb_n, 1);
            @(negedge clk);
        end
        // table-driven scenarios
        for (int v = 0; v < 6; v++) begin
            int base_c;
            int base_e;
            int t;
            base_c = cells_done;
            base_e = errs_seen;
            pend[1] = int'(VEC[v].c1);
            pend[2] = int'(VEC[v].c2);
            pend[3] = int'(VEC[v].c3);
            junk[1] = int'(VEC[v].j1);
            junk[2] = int'(VEC[v].j2);
            junk[3] = int'(VEC[v].j3);
            t = 0;
            while ((cells_done - base_c) < int'(VEC[v].cells) && t < 3000) begin
                @(negedge clk);
                t++;
            end
            repeat (10) @(negedge clk);
            chk(cells_done - base_c == int'(VEC[v].cells), "R5 cells delivered",
                cells_done - base_c, VEC[v].cells);
            chk(errs_seen - base_e == int'(VEC[v].errs), "R8 error pulses",
                errs_seen - base_e, VEC[v].errs);
            chk(pend[1] + pend[2] + pend[3] == 0, "R7 every pending PHY served",
                pend[1] + pend[2] + pend[3], 0);
            chk(utp_enb_n == 1'b1, "R4 enable negated when idle", utp_enb_n, 1);
        end
        // directed: reset mid-stream returns to reset state
        pend[1] = 1;
        junk[1] = 0;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(utp_enb_n == 1'b1, "R9 enable negated after reset", utp_enb_n, 1);
        chk(utp_addr == 5'h01, "R9 address after reset", utp_addr, 5'h01);
        chk(cell_valid == 1'b0, "R9 valid after reset", cell_valid, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule